// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block walks a ring of transmit buffer descriptors kept in a small register-mapped store. Software fills a descriptor with a frame length, a buffer address and control flags, then hands it to hardware by setting its ownership bit. The sequencer finds the descriptor, issues a one-cycle frame request to a transmit port and waits for a completion carrying a 9-bit result. It then writes the result back into the descriptor, returns ownership to software and, when the descriptor asks for it, flags a transmit interrupt.

A single host port reaches every register. Word offsets 0x00, 0x04, 0x08 and 0x0C hold the mode, interrupt source, interrupt mask and ring size. Descriptor `i` occupies byte offset `0x400 + 8*i` for its control/status word and `0x404 + 8*i` for its buffer address. Reads are combinational. Unmapped or unaligned addresses read as zero and ignore writes. Slots at or above the ring size belong to the receive side and the sequencer never touches them.

Top module: `txring_seq`

## Requirements
- R1: After reset the request and interrupt outputs are low, the mode, source and mask registers read 0, the ring size reads 64, and every descriptor status word reads 0.
- R2: A write to the ring size register stores the written value when it is at most 128 and stores 128 when it is larger.
- R3: A descriptor whose bit 15 (owned) is set yields exactly one single-cycle request. The request carries bits 31:16 as length, the second word as buffer address, bit 12 as pad and bit 11 as CRC.
- R4: While the current descriptor has bit 15 clear, no request is issued and the sequencer keeps polling that same descriptor, even when later descriptors are owned.
- R5: After completion the pointer moves to the next descriptor. It returns to descriptor 0 when bit 13 (wrap) was set or when the finished index was ring size minus one.
- R6: On completion the status word gets bit 15 cleared and bits 8:0 replaced by the completion result, and keeps bits 31:16 and 14:9. The result bits are: 0 carrier lost, 1 deferred, 2 late collision, 3 retry limit, 7:4 retry count, 8 underrun.
- R7: On completion of a descriptor with bit 14 set, source bit 1 (error) is set if any of result bits 0, 2, 3 or 8 is set, and source bit 0 (done) is set otherwise. With bit 14 clear the source is unchanged.
- R8: Writing the source register clears each bit written as 1 and leaves the others unchanged. A completion event in the same cycle as a clear leaves its bit set.
- R9: The interrupt output is high exactly when some source bit and its mask bit (mask bits 1:0) are both set.
- R10: Mode bit 1 enables transmission. While it is clear no new request starts, and a frame already requested still completes and is written back.
- R11: With a ring size of 0 no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | HOST_AW | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from host_addr) |
| tx_req | output | 1 | One-cycle frame request |
| tx_len | output | 16 | Frame length of the request |
| tx_buf_addr | output | 32 | Buffer address of the request |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Completion strobe for the outstanding frame |
| tx_status | input | 9 | Completion result, valid with tx_done |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The assertions assume that `tx_done` is a single-cycle strobe that arrives only while a requested frame is outstanding. They also assume that the ring size changes only while the pointer is below the new size. The bench answers each request with exactly one completion, two cycles after it sees the request. It shrinks the ring only when the pointer is already inside the smaller ring, and it uses word-aligned addresses throughout. In one deliberate case, a source clear collides with a completion in the same cycle.

// File: rtl/txr_pkg.sv
package txr_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned RES_W     = 9;
  localparam int unsigned DESC_BASE = 'h400;

  localparam int unsigned B_OWN  = 15;
  localparam int unsigned B_IRQ  = 14;
  localparam int unsigned B_WRAP = 13;
  localparam int unsigned B_PAD  = 12;
  localparam int unsigned B_CRC  = 11;

  // result bits that count as a failed transmission: underrun, retry limit,
  // late collision, carrier lost
  localparam logic [RES_W-1:0] FAIL_BITS = 9'h10D;

  typedef enum logic [1:0] {ST_POLL, ST_SEND, ST_WAIT} seq_state_e;

  typedef struct packed {
    logic [15:0]       len;
    logic [WORD_W-1:0] buf_addr;
    logic              pad;
    logic              crc;
  } frame_req_t;

  function automatic logic [WORD_W-1:0] merge_result(input logic [WORD_W-1:0] word,
                                                     input logic [RES_W-1:0]  res);
    return {word[31:16], 1'b0, word[14:9], res};
  endfunction

  function automatic logic [1:0] completion_event(input logic [WORD_W-1:0] word,
                                                  input logic [RES_W-1:0]  res);
    if (!word[B_IRQ]) return 2'b00;
    return (|(res & FAIL_BITS)) ? 2'b10 : 2'b01;
  endfunction

  function automatic int unsigned clamp_ring(input logic [WORD_W-1:0] v,
                                             input int unsigned       lim);
    return (v > lim) ? lim : int'(v);
  endfunction

  function automatic int unsigned next_slot(input int unsigned cur, input logic wrap,
                                            input int unsigned ring);
    return (wrap || (cur + 1 >= ring)) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem
  import txr_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned IW    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_we,
  input  logic              hw_word,
  input  logic [IW-1:0]     hw_idx,
  input  logic [WORD_W-1:0] hw_data,
  input  logic              sq_we,
  input  logic [IW-1:0]     sq_idx,
  input  logic [WORD_W-1:0] sq_data,
  output logic [WORD_W-1:0] rd_stat,
  output logic [WORD_W-1:0] rd_buf,
  output logic [WORD_W-1:0] sq_stat,
  output logic [WORD_W-1:0] sq_buf
);

  logic [WORD_W-1:0] stat_q [DEPTH];
  logic [WORD_W-1:0] buf_q  [DEPTH];
  logic              host_stat_we;

  // sequencer write-back wins a same-slot collision
  assign host_stat_we = hw_we && !hw_word && !(sq_we && sq_idx == hw_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) stat_q[i] <= '0;
    end else begin
      if (sq_we) stat_q[sq_idx] <= sq_data;
      if (host_stat_we) stat_q[hw_idx] <= hw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (hw_we && hw_word) buf_q[hw_idx] <= hw_data;
  end

  assign rd_stat = stat_q[hw_idx];
  assign rd_buf  = buf_q[hw_idx];
  assign sq_stat = stat_q[sq_idx];
  assign sq_buf  = buf_q[sq_idx];

  assert_wb_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sq_we |=> stat_q[$past(sq_idx)] == $past(sq_data));

endmodule

// File: rtl/txr_irq.sv
module txr_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set_ev,
  input  logic       clr_we,
  input  logic [1:0] clr_bits,
  input  logic       mask_we,
  input  logic [1:0] mask_data,
  output logic [1:0] src,
  output logic [1:0] mask,
  output logic       irq
);

  logic [1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src  <= '0;
      mask <= '0;
    end else begin
      src <= (src & ~clr_eff) | set_ev;
      if (mask_we) mask <= mask_data;
    end
  end

  assign irq = |(src & mask);

  assert_src_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && set_ev == 2'b00) |=> $stable(src));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev[0] |=> src[0]);

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 2'b00) |-> !irq);

endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int unsigned IW = 7,
  parameter int unsigned RW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [RW-1:0]     ring_size,
  input  logic [WORD_W-1:0] cur_stat,
  input  logic [WORD_W-1:0] cur_buf,
  input  logic              tx_done,
  input  logic [RES_W-1:0]  tx_status,
  output logic [IW-1:0]     idx,
  output logic              tx_req,
  output frame_req_t        frame,
  output logic              wb_we,
  output logic [WORD_W-1:0] wb_data,
  output logic [1:0]        irq_set
);

  seq_state_e state_q;
  logic [IW-1:0] idx_q;
  frame_req_t frame_q;
  logic start_ok;
  logic finish;

  assign start_ok = (state_q == ST_POLL) && tx_en && (ring_size != '0) && cur_stat[B_OWN];
  assign finish   = (state_q == ST_WAIT) && tx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POLL;
      idx_q   <= '0;
      frame_q <= '0;
    end else begin
      unique case (state_q)
        ST_POLL: if (start_ok) begin
          frame_q <= '{len: cur_stat[31:16], buf_addr: cur_buf,
                       pad: cur_stat[B_PAD], crc: cur_stat[B_CRC]};
          state_q <= ST_SEND;
        end
        ST_SEND: state_q <= ST_WAIT;
        ST_WAIT: if (tx_done) begin
          idx_q   <= IW'(next_slot(32'(idx_q), cur_stat[B_WRAP], 32'(ring_size)));
          state_q <= ST_POLL;
        end
        default: state_q <= ST_POLL;
      endcase
    end
  end

  assign idx     = idx_q;
  assign tx_req  = (state_q == ST_SEND);
  assign frame   = frame_q;
  assign wb_we   = finish;
  assign wb_data = merge_result(cur_stat, tx_status);
  assign irq_set = finish ? completion_event(cur_stat, tx_status) : 2'b00;

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);

  assert_req_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(cur_stat[B_OWN]));

  assert_req_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(tx_en));

  assert_req_ring_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(ring_size != '0));

  assert_hold_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL) |=> $stable(idx_q));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && cur_stat[B_WRAP]) |=> (idx_q == '0));

endmodule

// File: rtl/txring_seq.sv
module txring_seq
  import txr_pkg::*;
#(
  parameter int unsigned RING_MAX   = 128,
  parameter int unsigned RING_RESET = 64,
  parameter int unsigned HOST_AW    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               tx_req,
  output logic [15:0]        tx_len,
  output logic [31:0]        tx_buf_addr,
  output logic               tx_pad,
  output logic               tx_crc,
  input  logic               tx_done,
  input  logic [8:0]         tx_status,
  output logic               tx_irq
);

  localparam int unsigned IW = $clog2(RING_MAX);
  localparam int unsigned RW = $clog2(RING_MAX + 1);
  localparam logic [HOST_AW-1:0] A_MODE = HOST_AW'('h00);
  localparam logic [HOST_AW-1:0] A_SRC  = HOST_AW'('h04);
  localparam logic [HOST_AW-1:0] A_MASK = HOST_AW'('h08);
  localparam logic [HOST_AW-1:0] A_RING = HOST_AW'('h0C);
  localparam int unsigned MODE_TXEN = 1;

  logic [HOST_AW-1:0] desc_off;
  logic               desc_hit;
  logic [IW-1:0]      host_idx;
  logic               host_word;

  logic               txen_q;
  logic [RW-1:0]      ring_q;

  logic [WORD_W-1:0]  rd_stat, rd_buf, sq_stat, sq_buf;
  logic [IW-1:0]      sq_idx;
  logic               wb_we;
  logic [WORD_W-1:0]  wb_data;
  logic [1:0]         irq_set, src, mask;
  frame_req_t         frame;

  // host address decode
  assign desc_off  = host_addr - HOST_AW'(DESC_BASE);
  assign desc_hit  = (host_addr >= HOST_AW'(DESC_BASE)) && (desc_off[1:0] == 2'b00) &&
                     ((desc_off >> 3) < HOST_AW'(RING_MAX));
  assign host_idx  = desc_off[IW+2:3];
  assign host_word = desc_off[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txen_q <= 1'b0;
      ring_q <= RW'(RING_RESET);
    end else if (host_wr) begin
      if (host_addr == A_MODE) txen_q <= host_wdata[MODE_TXEN];
      if (host_addr == A_RING) ring_q <= RW'(clamp_ring(host_wdata, RING_MAX));
    end
  end

  txr_desc_mem #(.DEPTH(RING_MAX), .IW(IW)) i_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_we   (host_wr && desc_hit),
    .hw_word (host_word),
    .hw_idx  (host_idx),
    .hw_data (host_wdata),
    .sq_we   (wb_we),
    .sq_idx  (sq_idx),
    .sq_data (wb_data),
    .rd_stat (rd_stat),
    .rd_buf  (rd_buf),
    .sq_stat (sq_stat),
    .sq_buf  (sq_buf)
  );

  txr_seq #(.IW(IW), .RW(RW)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (txen_q),
    .ring_size (ring_q),
    .cur_stat  (sq_stat),
    .cur_buf   (sq_buf),
    .tx_done   (tx_done),
    .tx_status (tx_status),
    .idx       (sq_idx),
    .tx_req    (tx_req),
    .frame     (frame),
    .wb_we     (wb_we),
    .wb_data   (wb_data),
    .irq_set   (irq_set)
  );

  txr_irq i_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_ev    (irq_set),
    .clr_we    (host_wr && host_addr == A_SRC),
    .clr_bits  (host_wdata[1:0]),
    .mask_we   (host_wr && host_addr == A_MASK),
    .mask_data (host_wdata[1:0]),
    .src       (src),
    .mask      (mask),
    .irq       (tx_irq)
  );

  assign tx_len      = frame.len;
  assign tx_buf_addr = frame.buf_addr;
  assign tx_pad      = frame.pad;
  assign tx_crc      = frame.crc;

  always_comb begin
    host_rdata = '0;
    if (desc_hit) begin
      host_rdata = host_word ? rd_buf : rd_stat;
    end else begin
      case (host_addr)
        A_MODE:  host_rdata = {30'd0, txen_q, 1'b0};
        A_SRC:   host_rdata = {30'd0, src};
        A_MASK:  host_rdata = {30'd0, mask};
        A_RING:  host_rdata = 32'(ring_q);
        default: host_rdata = '0;
      endcase
    end
  end

  assert_ring_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ring_q <= RW'(RING_MAX));

endmodule

// File: tb/test_txring_seq.sv
module test_txring_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [11:0] host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        tx_req;
  logic [15:0] tx_len;
  logic [31:0] tx_buf_addr;
  logic        tx_pad;
  logic        tx_crc;
  logic        tx_done;
  logic [8:0]  tx_status;
  logic        tx_irq;

  int checks  = 0;
  int errors  = 0;
  int req_cnt = 0;

  always #2 clk = ~clk;

  localparam logic [11:0] R_MODE = 12'h000;
  localparam logic [11:0] R_SRC  = 12'h004;
  localparam logic [11:0] R_MASK = 12'h008;
  localparam logic [11:0] R_RING = 12'h00C;

  localparam logic [31:0] VEC_CTRL [5] = '{32'h0040_4800, 32'h0020_5800, 32'h05EE_4000,
                                           32'h0100_08FF, 32'h003C_7000};
  localparam logic [31:0] VEC_BUF  [5] = '{32'h1000_0000, 32'h1000_0600, 32'h1000_0C00,
                                           32'h1000_1200, 32'h1000_1800};
  localparam logic [8:0]  VEC_ST   [5] = '{9'h000, 9'h031, 9'h0F2, 9'h100, 9'h004};
  localparam logic [1:0]  VEC_SRC  [5] = '{2'b01, 2'b10, 2'b01, 2'b00, 2'b10};

  txring_seq i_txring_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .tx_req      (tx_req),
    .tx_len      (tx_len),
    .tx_buf_addr (tx_buf_addr),
    .tx_pad      (tx_pad),
    .tx_crc      (tx_crc),
    .tx_done     (tx_done),
    .tx_status   (tx_status),
    .tx_irq      (tx_irq)
  );

  always @(negedge clk) if (tx_req) req_cnt++;

  function automatic logic [11:0] stat_at(input int k);
    return 12'(32'h400 + 8 * k);
  endfunction

  function automatic logic [11:0] buf_at(input int k);
    return 12'(32'h404 + 8 * k);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_req(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (tx_req) begin ok = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  task automatic complete(input logic [8:0] st);
    @(negedge clk);
    @(negedge clk);
    tx_done = 1'b1; tx_status = st;
    @(negedge clk);
    tx_done = 1'b0; tx_status = '0;
  endtask

  task automatic expect_req(input string tag, input logic [31:0] exp_buf);
    logic ok;
    wait_req(ok);
    chk({tag, " request seen"}, 32'(ok), 32'd1);
    chk({tag, " buffer address"}, tx_buf_addr, exp_buf);
  endtask

  task automatic quiet(input string tag, input int cycles);
    int base;
    base = req_cnt;
    repeat (cycles) @(negedge clk);
    chk({tag, " no request"}, 32'(req_cnt - base), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..all actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic ok;
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    tx_done = 1'b0; tx_status = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 tx_req", 32'(tx_req), 32'd0);
    chk("R1 tx_irq", 32'(tx_irq), 32'd0);
    rd(R_MODE, v); chk("R1 mode", v, 32'd0);
    rd(R_SRC, v);  chk("R1 source", v, 32'd0);
    rd(R_MASK, v); chk("R1 mask", v, 32'd0);
    rd(R_RING, v); chk("R1 ring size", v, 32'd64);
    rd(stat_at(5), v); chk("R1 status word", v, 32'd0);

    // R2 clamp
    wr(R_RING, 32'd200); rd(R_RING, v); chk("R2 clamp 200", v, 32'd128);
    wr(R_RING, 32'h0001_0005); rd(R_RING, v); chk("R2 clamp wide", v, 32'd128);
    wr(R_RING, 32'd128); rd(R_RING, v); chk("R2 exact 128", v, 32'd128);
    wr(R_RING, 32'd8);   rd(R_RING, v); chk("R2 store 8", v, 32'd8);

    wr(R_MASK, 32'd3);
    wr(R_MODE, 32'd2);
    rd(R_MODE, v); chk("R10 mode readback", v, 32'd2);

    // table walk: R3 R6 R7 R8 R9, last entry wraps (R5)
    for (int k = 0; k < 5; k++) begin
      wr(buf_at(k), VEC_BUF[k]);
      wr(stat_at(k), VEC_CTRL[k] | 32'h8000);
      wait_req(ok);
      chk("R3 request seen", 32'(ok), 32'd1);
      chk("R3 length", 32'(tx_len), 32'(VEC_CTRL[k][31:16]));
      chk("R3 buffer", tx_buf_addr, VEC_BUF[k]);
      chk("R3 pad", 32'(tx_pad), 32'(VEC_CTRL[k][12]));
      chk("R3 crc", 32'(tx_crc), 32'(VEC_CTRL[k][11]));
      complete(VEC_ST[k]);
      chk("R3 single pulse", 32'(tx_req), 32'd0);
      rd(stat_at(k), v);
      chk("R6 write-back", v, ((VEC_CTRL[k] | 32'h8000) & ~32'h0000_81FF) | 32'(VEC_ST[k]));
      rd(R_SRC, v); chk("R7 source", v, 32'(VEC_SRC[k]));
      chk("R9 irq", 32'(tx_irq), 32'(VEC_SRC[k] != 2'b00));
      wr(R_SRC, 32'd3); rd(R_SRC, v); chk("R8 clear", v, 32'd0);
    end

    // R5 wrap bit returned pointer to descriptor 0
    wr(buf_at(0), 32'h2000_0000);
    wr(stat_at(0), 32'h0010_8800);
    expect_req("R5 wrap to 0", 32'h2000_0000);
    complete(9'h000);

    // R4 pointer at 1: descriptor 1 not owned, descriptor 2 owned
    wr(buf_at(2), 32'h3000_0000);
    wr(stat_at(2), 32'h0010_8000);
    wr(buf_at(1), 32'h2100_0000);
    wr(stat_at(1), 32'h0010_0000);
    quiet("R4 no skip", 20);
    wr(stat_at(1), 32'h0010_8000);
    expect_req("R4 same descriptor", 32'h2100_0000);
    complete(9'h000);
    expect_req("R5 advance", 32'h3000_0000);
    complete(9'h000);

    // R5 ring-size end: pointer 3, ring 4
    wr(R_RING, 32'd4);
    wr(buf_at(3), 32'h4000_0000);
    wr(stat_at(3), 32'h0010_8000);
    expect_req("R5 last slot", 32'h4000_0000);
    complete(9'h000);
    wr(buf_at(0), 32'h5000_0000);
    wr(stat_at(0), 32'h0010_8000);
    expect_req("R5 ring end to 0", 32'h5000_0000);
    complete(9'h000);

    // R10 enable gate, pointer 1
    wr(R_MODE, 32'd0);
    wr(buf_at(1), 32'h6000_0000);
    wr(stat_at(1), 32'h0010_8000);
    quiet("R10 disabled", 20);
    wr(R_MODE, 32'd2);
    expect_req("R10 enabled", 32'h6000_0000);
    wr(R_MODE, 32'd0);
    complete(9'h000);
    rd(stat_at(1), v); chk("R10 in-flight completes", v, 32'h0010_0000);
    rd(R_MODE, v); chk("R10 mode cleared", v, 32'd0);

    // R11 ring size zero, pointer 2
    wr(R_RING, 32'd0);
    wr(R_MODE, 32'd2);
    wr(buf_at(2), 32'h7000_0000);
    wr(stat_at(2), 32'h0010_8000);
    quiet("R11 zero ring", 20);
    wr(R_RING, 32'd4);
    expect_req("R11 ring restored", 32'h7000_0000);
    complete(9'h000);

    // R8 set wins over simultaneous clear, pointer 3
    wr(buf_at(3), 32'h8000_0000);
    wr(stat_at(3), 32'h0010_C000);
    expect_req("R8 setup", 32'h8000_0000);
    @(negedge clk);
    @(negedge clk);
    tx_done = 1'b1; tx_status = 9'h000;
    host_wr = 1'b1; host_addr = R_SRC; host_wdata = 32'd3;
    @(negedge clk);
    tx_done = 1'b0; host_wr = 1'b0;
    rd(R_SRC, v); chk("R8 set wins", v, 32'd1);
    wr(R_SRC, 32'd0); rd(R_SRC, v); chk("R8 zero write keeps", v, 32'd1);

    // R9 mask gating
    wr(R_MASK, 32'd2); #1 chk("R9 masked off", 32'(tx_irq), 32'd0);
    wr(R_MASK, 32'd1); #1 chk("R9 mask on", 32'(tx_irq), 32'd1);
    wr(R_SRC, 32'd1); #1 chk("R9 cleared", 32'(tx_irq), 32'd0);
    rd(R_SRC, v); chk("R8 cleared bit 0", v, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule